// File: doc/BRIEF.md
# Capture/Reload Up-Down Timer

A 16-bit timer/counter with a companion 16-bit capture/reload register. It serves as an interval timer, an event counter on an external pin, a pulse-width capture unit, a periodic reload timer that can count in both directions, or a baud-rate source for a serial port. The mode is picked by a few control inputs. The counter steps either on a machine-cycle enable (timer function), on a falling edge of the count pin (counter function) or, in baud mode, on a faster state-time enable.

Software writes the counter and the reload register through dedicated write strobes. It clears the two event flags through dedicated clear strobes. The interrupt request combines the flags. Register decoding and the serial port itself sit outside the block. In baud mode each rollover produces a one-cycle tick, which a serial port divides further.

Top module: `capreload_timer`

## Requirements
- R1: After reset the counter, the reload register, both flags, the interrupt request and the baud tick are all 0.
- R2: With the run input at 1, the count-source select at 0 (timer function) and baud mode off, the counter steps by one in each cycle with the machine-cycle enable high. The state-time enable has no effect outside baud mode. With the run input at 0 the counter holds.
- R3: With the count-source select at 1, the count pin is sampled in each machine-cycle enable cycle. The counter steps only when the previous sample was 1 and the current sample is 0. Holding the pin low gives no further steps. The sample history resets to 0.
- R4: In capture mode (capSel = 1, both clock selects 0), a step from 0xFFFF wraps the counter to 0x0000 and sets the overflow flag.
- R5: In capture mode with extEn = 1, a falling edge on the trigger pin copies the counter into the reload register and sets the external flag. The edge is sampled like the count pin in R3. With extEn = 0 the edge changes neither.
- R6: In reload mode (capSel = 0, both clock selects 0) with downEn = 0, a step from 0xFFFF loads the reload value and sets the overflow flag. With extEn = 1, a falling trigger edge also loads the reload value and sets the external flag.
- R7: In reload mode with downEn = 1, the trigger pin level gives the direction: 1 counts up and 0 counts down. Counting down, a step taken while the counter equals the reload value loads 0xFFFF and sets the overflow flag. Trigger edges then neither reload nor set the external flag.
- R8: In reload mode with downEn = 1, the external flag toggles on every overflow and underflow, and it does not drive the interrupt request.
- R9: With either clock select at 1 (baud mode), the timer function steps on the state-time enable and ignores the machine-cycle enable. A step from 0xFFFF loads the reload value, leaves the overflow flag unchanged, and raises the baud tick for exactly the following cycle.
- R10: In baud mode with extEn = 1, a falling trigger edge sets the external flag and leaves the counter unchanged.
- R11: The interrupt request is the OR of the two flags, subject to R8. A flag stays set until its clear strobe. When a set and a clear land in the same cycle, the set wins.
- R12: A counter or reload write is visible in the next cycle and has priority over any hardware update in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mcEn | input | 1 | Machine-cycle enable; also paces pin sampling |
| stEn | input | 1 | State-time enable, used in baud mode |
| cntPin | input | 1 | External count pin |
| trigPin | input | 1 | External trigger / direction pin |
| runEn | input | 1 | Run control |
| ctrSel | input | 1 | 0 = timer function, 1 = counter function |
| capSel | input | 1 | 1 = capture mode, 0 = reload mode |
| extEn | input | 1 | Enables trigger-pin edge actions |
| downEn | input | 1 | Enables up/down counting in reload mode |
| txClkSel | input | 1 | Transmit clock select (baud mode) |
| rxClkSel | input | 1 | Receive clock select (baud mode) |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | 16 | Counter write value |
| rldWrEn | input | 1 | Reload register write strobe |
| rldWrData | input | 16 | Reload register write value |
| ovfClr | input | 1 | Overflow flag clear strobe |
| extClr | input | 1 | External flag clear strobe |
| cntVal | output | 16 | Counter value |
| rldVal | output | 16 | Capture/reload register value |
| ovfFlag | output | 1 | Overflow/underflow flag |
| extFlag | output | 1 | External flag |
| irq | output | 1 | Interrupt request |
| baudTick | output | 1 | One-cycle pulse per baud-mode rollover |

## Verification
The bench drives down-counting past the reload value. A design that compares against zero instead would never reach 0xFFFF, and one that tests equality after stepping would reload one count early. It checks that baud-mode rollover reloads without raising the overflow flag. It checks that a trigger edge in baud mode sets the external flag with the counter untouched; a design reusing the reload-mode path would corrupt the count. With up/down counting on, it confirms that the external flag toggles yet stays out of the interrupt request. It also confirms that a flag set racing a software clear survives, and that a level-held count pin steps only once; an edge detector that compares against the wrong sample would step repeatedly or not at all.

// File: rtl/tmr2_pkg.sv
package tmr2_pkg;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_BAUD    = 2'd2
  } tmrMode_e;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic step;     // count one
    logic down;     // direction of step
    logic loadRld;  // counter <= reload value
    logic loadMax;  // counter <= all ones
    logic capture;  // reload register <= counter
    logic setOvf;
    logic setExt;
    logic togExt;
    logic tick;     // baud rollover
  } tmrStrobe_t;

endpackage

// File: rtl/tmr2_edge.sv
module tmr2_edge (
  input  logic clk,
  input  logic rstN,
  input  logic smpEn,
  input  logic pin,
  output logic fall
);
  logic prevQ;

  always_ff @(posedge clk) begin
    if (!rstN)      prevQ <= 1'b0;
    else if (smpEn) prevQ <= pin;
  end

  // previous sample high, current sample low
  assign fall = smpEn & prevQ & ~pin;
endmodule

// File: rtl/tmr2_ctrl.sv
module tmr2_ctrl
  import tmr2_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         mcEn,
  input  logic         stEn,
  input  logic         cntPin,
  input  logic         trigPin,
  input  logic         runEn,
  input  logic         ctrSel,
  input  logic         capSel,
  input  logic         extEn,
  input  logic         downEn,
  input  logic         txClkSel,
  input  logic         rxClkSel,
  input  logic [W-1:0] cntVal,
  input  logic [W-1:0] rldVal,
  output tmrStrobe_t   strb,
  output logic         extIrqOff
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam int NPIN = 2;

  logic [NPIN-1:0] pinIn;
  logic [NPIN-1:0] pinFall;
  assign pinIn = {trigPin, cntPin};

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_edge
      tmr2_edge u_edge (
        .clk  (clk),
        .rstN (rstN),
        .smpEn(mcEn),
        .pin  (pinIn[gi]),
        .fall (pinFall[gi])
      );
    end
  endgenerate

  logic     cntFall, trigFall;
  tmrMode_e mode;
  logic     upDownOn, countDown, stepEn, atMax, atRld;

  assign cntFall  = pinFall[0];
  assign trigFall = pinFall[1];

  always_comb begin
    if (txClkSel || rxClkSel) mode = MODE_BAUD;
    else if (capSel)          mode = MODE_CAPTURE;
    else                      mode = MODE_RELOAD;
  end

  assign upDownOn  = (mode == MODE_RELOAD) && downEn;
  assign countDown = upDownOn && !trigPin;
  assign stepEn    = runEn && (ctrSel ? cntFall
                                      : ((mode == MODE_BAUD) ? stEn : mcEn));
  assign atMax     = (cntVal == MAXV);
  assign atRld     = (cntVal == rldVal);
  assign extIrqOff = upDownOn;

  always_comb begin
    strb      = '0;
    strb.step = stepEn;
    strb.down = countDown;
    unique case (mode)
      MODE_CAPTURE: begin
        if (stepEn && atMax) strb.setOvf = 1'b1;
        if (extEn && trigFall) begin
          strb.capture = 1'b1;
          strb.setExt  = 1'b1;
        end
      end
      MODE_RELOAD: begin
        if (upDownOn) begin
          if (stepEn && countDown && atRld) begin
            strb.loadMax = 1'b1;
            strb.setOvf  = 1'b1;
            strb.togExt  = 1'b1;
          end else if (stepEn && !countDown && atMax) begin
            strb.loadRld = 1'b1;
            strb.setOvf  = 1'b1;
            strb.togExt  = 1'b1;
          end
        end else begin
          if (stepEn && atMax) begin
            strb.loadRld = 1'b1;
            strb.setOvf  = 1'b1;
          end
          if (extEn && trigFall) begin
            strb.loadRld = 1'b1;
            strb.setExt  = 1'b1;
          end
        end
      end
      MODE_BAUD: begin
        if (stepEn && atMax) begin
          strb.loadRld = 1'b1;
          strb.tick    = 1'b1;
        end
        if (extEn && trigFall) strb.setExt = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  // trigger edges never move the count while counting both ways
  AST_UPDOWN_NO_TRIG_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (upDownOn && !stepEn) |-> (!strb.loadRld && !strb.setExt)); // R7
endmodule

// File: rtl/tmr2_datapath.sv
module tmr2_datapath
  import tmr2_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrobe_t   strb,
  input  logic         cntWrEn,
  input  logic [W-1:0] cntWrData,
  input  logic         rldWrEn,
  input  logic [W-1:0] rldWrData,
  input  logic         ovfClr,
  input  logic         extClr,
  output logic [W-1:0] cntVal,
  output logic [W-1:0] rldVal,
  output logic         ovfFlag,
  output logic         extFlag,
  output logic         baudTick
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cntNext;

  always_comb begin
    cntNext = cntVal;
    if (cntWrEn)           cntNext = cntWrData;
    else if (strb.loadMax) cntNext = MAXV;
    else if (strb.loadRld) cntNext = rldVal;
    else if (strb.step)    cntNext = strb.down ? (cntVal - ONE) : (cntVal + ONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal   <= '0;
      rldVal   <= '0;
      ovfFlag  <= 1'b0;
      extFlag  <= 1'b0;
      baudTick <= 1'b0;
    end else begin
      cntVal   <= cntNext;
      baudTick <= strb.tick;
      if (rldWrEn)           rldVal <= rldWrData;
      else if (strb.capture) rldVal <= cntVal;
      if (strb.setOvf)       ovfFlag <= 1'b1;
      else if (ovfClr)       ovfFlag <= 1'b0;
      if (strb.setExt)       extFlag <= 1'b1;
      else if (strb.togExt)  extFlag <= ~extFlag;
      else if (extClr)       extFlag <= 1'b0;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag); // R11
  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (cntVal == $past(cntWrData))); // R12
  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !rldWrEn) |=> (rldVal == $past(cntVal))); // R5
endmodule

// File: rtl/capreload_timer.sv
module capreload_timer
  import tmr2_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         mcEn,
  input  logic         stEn,
  input  logic         cntPin,
  input  logic         trigPin,
  input  logic         runEn,
  input  logic         ctrSel,
  input  logic         capSel,
  input  logic         extEn,
  input  logic         downEn,
  input  logic         txClkSel,
  input  logic         rxClkSel,
  input  logic         cntWrEn,
  input  logic [W-1:0] cntWrData,
  input  logic         rldWrEn,
  input  logic [W-1:0] rldWrData,
  input  logic         ovfClr,
  input  logic         extClr,
  output logic [W-1:0] cntVal,
  output logic [W-1:0] rldVal,
  output logic         ovfFlag,
  output logic         extFlag,
  output logic         irq,
  output logic         baudTick
);
  tmrStrobe_t strb;
  logic       extIrqOff;

  tmr2_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mcEn(mcEn), .stEn(stEn),
    .cntPin(cntPin), .trigPin(trigPin), .runEn(runEn), .ctrSel(ctrSel),
    .capSel(capSel), .extEn(extEn), .downEn(downEn),
    .txClkSel(txClkSel), .rxClkSel(rxClkSel),
    .cntVal(cntVal), .rldVal(rldVal),
    .strb(strb), .extIrqOff(extIrqOff)
  );

  tmr2_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .rldWrEn(rldWrEn), .rldWrData(rldWrData),
    .ovfClr(ovfClr), .extClr(extClr),
    .cntVal(cntVal), .rldVal(rldVal),
    .ovfFlag(ovfFlag), .extFlag(extFlag), .baudTick(baudTick)
  );

  assign irq = ovfFlag | (extFlag & ~extIrqOff);

  AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    ((txClkSel || rxClkSel) && !ovfFlag) |=> !ovfFlag); // R9
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWrEn && !extEn) |=> $stable(cntVal)); // R2
endmodule

// File: tb/capreload_timer_bench.sv
`timescale 1ns/1ps
module capreload_timer_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mcEn = 0, stEn = 0, cntPin = 0, trigPin = 0, runEn = 0, ctrSel = 0;
  logic capSel = 1, extEn = 0, downEn = 0, txClkSel = 0, rxClkSel = 0;
  logic cntWrEn = 0, rldWrEn = 0, ovfClr = 0, extClr = 0;
  logic [W-1:0] cntWrData = '0, rldWrData = '0;
  logic [W-1:0] cntVal, rldVal;
  logic ovfFlag, extFlag, irq, baudTick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  capreload_timer #(.W(W)) u_capreload_timer (
    .clk(clk), .rstN(rstN), .mcEn(mcEn), .stEn(stEn),
    .cntPin(cntPin), .trigPin(trigPin), .runEn(runEn), .ctrSel(ctrSel),
    .capSel(capSel), .extEn(extEn), .downEn(downEn),
    .txClkSel(txClkSel), .rxClkSel(rxClkSel),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .rldWrEn(rldWrEn), .rldWrData(rldWrData),
    .ovfClr(ovfClr), .extClr(extClr),
    .cntVal(cntVal), .rldVal(rldVal), .ovfFlag(ovfFlag),
    .extFlag(extFlag), .irq(irq), .baudTick(baudTick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // each helper drives at a falling edge; results are read at the next one
  task automatic idle();
    @(negedge clk);
  endtask
  task automatic mc();
    mcEn = 1; @(negedge clk); mcEn = 0;
  endtask
  task automatic st();
    stEn = 1; @(negedge clk); stEn = 0;
  endtask
  task automatic wrCnt(input logic [W-1:0] v);
    cntWrEn = 1; cntWrData = v; @(negedge clk); cntWrEn = 0;
  endtask
  task automatic wrRld(input logic [W-1:0] v);
    rldWrEn = 1; rldWrData = v; @(negedge clk); rldWrEn = 0;
  endtask
  task automatic clrAll();
    ovfClr = 1; extClr = 1; @(negedge clk); ovfClr = 0; extClr = 0;
  endtask

  task automatic t_reset();
    chk("R1 cnt", cntVal, 0);
    chk("R1 rld", rldVal, 0);
    chk("R1 ovf", ovfFlag, 0);
    chk("R1 ext", extFlag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tick", baudTick, 0);
  endtask

  task automatic t_timer();
    capSel = 1; ctrSel = 0; runEn = 0;
    wrCnt(16'h0100);
    runEn = 1;
    mc(); mc(); mc();
    chk("R2 three steps", cntVal, 16'h0103);
    st();
    chk("R2 stEn ignored", cntVal, 16'h0103);
    runEn = 0;
    mc(); mc();
    chk("R2 hold when stopped", cntVal, 16'h0103);
  endtask

  task automatic t_counter();
    ctrSel = 1; runEn = 0;
    wrCnt(16'h0000);
    runEn = 1;
    cntPin = 1; mc();
    chk("R3 rising no step", cntVal, 0);
    cntPin = 0; idle(); cntPin = 1; idle(); cntPin = 0;
    chk("R3 pin move without sample", cntVal, 0);
    mc();
    chk("R3 fall step", cntVal, 1);
    mc(); mc();
    chk("R3 low held", cntVal, 1);
    runEn = 0; ctrSel = 0;
  endtask

  task automatic t_capOvf();
    capSel = 1; runEn = 0;
    wrCnt(16'hFFFF);
    runEn = 1;
    mc();
    chk("R4 wrap", cntVal, 0);
    chk("R4 ovf", ovfFlag, 1);
    chk("R11 irq", irq, 1);
    runEn = 0;
    idle(); idle(); idle();
    chk("R11 ovf sticky", ovfFlag, 1);
    clrAll();
    chk("R11 cleared", ovfFlag, 0);
    chk("R11 irq cleared", irq, 0);
    // set and clear together: set wins
    wrCnt(16'hFFFF);
    runEn = 1; ovfClr = 1; mcEn = 1; @(negedge clk); mcEn = 0; ovfClr = 0;
    runEn = 0;
    chk("R11 set beats clear", ovfFlag, 1);
    clrAll();
  endtask

  task automatic t_capTrig();
    capSel = 1; runEn = 0; extEn = 0;
    wrRld(16'h0000);
    wrCnt(16'h1234);
    trigPin = 1; mc(); trigPin = 0; mc();
    chk("R5 disabled rld", rldVal, 0);
    chk("R5 disabled ext", extFlag, 0);
    extEn = 1;
    trigPin = 1; mc(); trigPin = 0; mc();
    chk("R5 capture", rldVal, 16'h1234);
    chk("R5 ext", extFlag, 1);
    chk("R11 irq from ext", irq, 1);
    extEn = 0;
    clrAll();
  endtask

  task automatic t_reload();
    capSel = 0; runEn = 0; extEn = 0; downEn = 0;
    wrRld(16'h8000);
    wrCnt(16'hFFFF);
    runEn = 1; mc(); runEn = 0;
    chk("R6 reload on ovf", cntVal, 16'h8000);
    chk("R6 ovf", ovfFlag, 1);
    clrAll();
    wrCnt(16'h0010);
    extEn = 1;
    trigPin = 1; mc(); trigPin = 0; mc();
    chk("R6 trig reload", cntVal, 16'h8000);
    chk("R6 trig ext", extFlag, 1);
    extEn = 0;
    clrAll();
  endtask

  task automatic t_updown();
    capSel = 0; downEn = 1; extEn = 1; runEn = 0;
    wrRld(16'h0005);
    wrCnt(16'h0007);
    trigPin = 1; mc();
    runEn = 1; trigPin = 0;
    mc();
    chk("R7 down step", cntVal, 16'h0006);
    chk("R7 trig edge no ext", extFlag, 0);
    mc();
    chk("R7 reach reload", cntVal, 16'h0005);
    chk("R7 no early underflow", ovfFlag, 0);
    mc();
    chk("R7 underflow loads max", cntVal, 16'hFFFF);
    chk("R7 underflow ovf", ovfFlag, 1);
    chk("R8 ext toggled on", extFlag, 1);
    runEn = 0;
    ovfClr = 1; idle(); ovfClr = 0;
    chk("R8 ext kept out of irq", irq, 0);
    trigPin = 1; runEn = 1;
    mc();
    runEn = 0;
    chk("R7 up overflow reload", cntVal, 16'h0005);
    chk("R8 ext toggled off", extFlag, 0);
    chk("R7 up ovf", ovfFlag, 1);
    downEn = 0; extEn = 0;
    clrAll();
  endtask

  task automatic t_baud();
    capSel = 0; runEn = 0; extEn = 0; ctrSel = 0;
    txClkSel = 1;
    wrRld(16'hFFFE);
    wrCnt(16'hFFFE);
    runEn = 1;
    st();
    chk("R9 state step", cntVal, 16'hFFFF);
    mc();
    chk("R9 mc ignored", cntVal, 16'hFFFF);
    st();
    chk("R9 rollover reload", cntVal, 16'hFFFE);
    chk("R9 tick high", baudTick, 1);
    chk("R9 no ovf", ovfFlag, 0);
    idle();
    chk("R9 tick one cycle", baudTick, 0);
    runEn = 0; extEn = 1;
    txClkSel = 0; rxClkSel = 1;
    wrCnt(16'h0042);
    trigPin = 1; mc(); trigPin = 0; mc();
    chk("R10 ext set", extFlag, 1);
    chk("R10 no reload", cntVal, 16'h0042);
    rxClkSel = 0; extEn = 0;
    clrAll();
  endtask

  task automatic t_writePri();
    capSel = 1; ctrSel = 0; runEn = 1;
    cntWrEn = 1; cntWrData = 16'hABCD; mcEn = 1;
    rldWrEn = 1; rldWrData = 16'h1357;
    @(negedge clk);
    cntWrEn = 0; mcEn = 0; rldWrEn = 0; runEn = 0;
    chk("R12 cnt write wins", cntVal, 16'hABCD);
    chk("R12 rld write", rldVal, 16'h1357);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_counter();
    t_capOvf();
    t_capTrig();
    t_reload();
    t_updown();
    t_baud();
    t_writePri();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule